// File: doc/BRIEF.md
# Control Transfer Stage Tracker

This block runs on the device side of a control endpoint. It follows each control transfer through its stages: setup, an optional data stage, and status. When a setup transaction completes, it takes the direction and byte length decoded from the request. It then counts the data-stage bytes against that length. It detects the end of the data stage from a short or zero-length packet, or when the count runs out. It treats the first token in the opposite direction as the start of the status stage.

For every token the packet engine presents, the block returns a response mode at once (normal, NAK or STALL) together with the data-toggle bit the engine should expect or send. A STALL given to an IN or OUT token puts the endpoint into a sticky halted state. Only the completion of a new SETUP transaction releases it. Request decoding and the packet engine itself live outside the block.

The packet engine gives the block two kinds of event, never both in the same cycle. A token strobe carries the token kind. A completion strobe carries the byte count and reports a transaction that finished successfully: for SETUP or OUT, a valid data packet was accepted; for IN, the host returned ACK.

Top module: `ctl_xfer_seq`

## Requirements
- R1: A SETUP token (kind code 0) is always answered with response code 0 (normal) and toggle preset 0, in every stage, including the halted stage.
- R2: When a SETUP transaction completes with a nonzero length, the stage output becomes 1 (data), and the data direction comes from the setup direction bit (1 = device to host). With a zero length, the stage becomes 2 (status), and the status stage uses IN (kind code 2).
- R3: The first data-stage token gets toggle preset 1. The preset inverts after each completed data-stage transaction. A NAK leaves it unchanged.
- R4: The data stage ends when a completed transaction carries fewer than MAX_PKT bytes (zero included) or uses up the remaining length. After that, a further token in the data direction gets response code 2 (STALL).
- R5: A data-stage completion that carries more bytes than remain moves the stage to 3 (halted).
- R6: In the data stage, a token opposite to the data direction starts the status stage. It gets toggle preset 1, and the stage becomes 2. This also holds when the last IN of a control read was never acknowledged.
- R7: In the status direction, the response is STALL (2) if the function reports an error, NAK (1) if it is busy, and otherwise normal (0). A completed status transaction of any byte count returns the stage to 0 (idle).
- R8: In the status stage, a token in the data direction gets STALL.
- R9: Any STALL given to an IN or OUT token moves the stage to 3. While halted, every IN (2) and OUT (1) token gets STALL, so no status stage follows, until a SETUP completes.
- R10: A data-direction token in the data stage gets STALL when the function reports an error, or NAK when it is busy. A NAK leaves the stage unchanged.
- R11: After reset the stage is 0 (idle). In idle, IN and OUT tokens get STALL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_valid | input | 1 | One-cycle strobe: a token has arrived |
| tok_kind | input | 2 | Token kind: 0 SETUP, 1 OUT, 2 IN, 3 reserved (answered NAK, no effect) |
| txn_done | input | 1 | One-cycle strobe: the last token's transaction completed successfully |
| txn_bytes | input | PKT_W | Bytes carried by the completed transaction |
| setup_dev2host | input | 1 | Decoded setup direction, sampled on SETUP completion |
| setup_len | input | LEN_W | Decoded setup length, sampled on SETUP completion |
| fn_busy | input | 1 | Function still processing |
| fn_error | input | 1 | Function cannot complete the request |
| rsp_mode | output | 2 | Response for the presented token: 0 normal, 1 NAK, 2 STALL |
| tog_preset | output | 1 | Data toggle for the presented token |
| stage | output | 2 | 0 idle, 1 data, 2 status, 3 halted |

## Verification
The hardest case to reach is the control read whose final IN acknowledgement was lost. In that case the data stage still has bytes outstanding and the toggle has not advanced, yet the next OUT token must open the status stage with toggle 1. The stimulus sends an IN token, answers it normally, and withholds the completion strobe. It then presents the OUT token. Reaching a data stage that ends on a zero-length packet takes the same deliberate pacing: the request is longer than the data, and the data is exactly two full packets.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

    typedef enum logic [1:0] {
        TK_SETUP = 2'd0,
        TK_OUT   = 2'd1,
        TK_IN    = 2'd2,
        TK_RSVD  = 2'd3
    } tok_e;

    typedef enum logic [1:0] {
        RS_GO    = 2'd0,
        RS_NAK   = 2'd1,
        RS_STALL = 2'd2,
        RS_RSVD  = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        SG_IDLE   = 2'd0,
        SG_DATA   = 2'd1,
        SG_STATUS = 2'd2,
        SG_HALT   = 2'd3
    } stage_e;

    // Answer given in the status direction
    function automatic rsp_e status_answer(input logic busy, input logic err);
        if (err)
            return RS_STALL;
        else if (busy)
            return RS_NAK;
        else
            return RS_GO;
    endfunction

endpackage

// File: rtl/ctl_len_meter.sv
module ctl_len_meter
    import ctl_seq_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int LEN_W   = 16,
    parameter int PKT_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] load_len_i,
    input  logic             take_i,
    input  logic [PKT_W-1:0] take_bytes_i,
    output logic             ended_o,
    output logic             over_o
);

    typedef struct packed {
        logic [LEN_W-1:0] remain;
        logic             ended;
    } meter_t;

    meter_t m_d, m_q;

    logic [LEN_W-1:0] bytes_w;
    logic             short_pkt;
    logic             exhaust;

    always_comb begin
        bytes_w   = LEN_W'(take_bytes_i);
        short_pkt = (take_bytes_i < PKT_W'(MAX_PKT));
        exhaust   = (bytes_w == m_q.remain);
        over_o    = (bytes_w > m_q.remain);
        m_d       = m_q;
        if (load_i) begin
            m_d.remain = load_len_i;
            m_d.ended  = (load_len_i == '0);
        end else if (take_i) begin
            if (over_o)
                m_d.remain = '0;
            else
                m_d.remain = m_q.remain - bytes_w;
            m_d.ended = m_q.ended | short_pkt | exhaust | over_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            m_q <= '{remain: '0, ended: 1'b0};
        else
            m_q <= m_d;
    end

    assign ended_o = m_q.ended;

endmodule

// File: rtl/ctl_resp_sel.sv
module ctl_resp_sel
    import ctl_seq_pkg::*;
(
    input  stage_e stage_i,
    input  logic   stat_in_i,
    input  logic   ended_i,
    input  logic   tog_i,
    input  tok_e   tok_kind_i,
    input  logic   busy_i,
    input  logic   err_i,
    output rsp_e   rsp_o,
    output logic   tog_o,
    output logic   flip_o
);

    logic is_io;
    logic is_in;
    logic to_status;

    always_comb begin
        is_io     = (tok_kind_i == TK_IN) || (tok_kind_i == TK_OUT);
        is_in     = (tok_kind_i == TK_IN);
        to_status = is_io && (is_in == stat_in_i);
        flip_o    = (stage_i == SG_DATA) && to_status;

        rsp_o = RS_STALL;
        if (tok_kind_i == TK_SETUP) begin
            rsp_o = RS_GO;
        end else if (!is_io) begin
            rsp_o = RS_NAK;
        end else begin
            unique case (stage_i)
                SG_IDLE:   rsp_o = RS_STALL;
                SG_HALT:   rsp_o = RS_STALL;
                SG_DATA: begin
                    if (to_status)
                        rsp_o = status_answer(busy_i, err_i);
                    else if (ended_i || err_i)
                        rsp_o = RS_STALL;
                    else if (busy_i)
                        rsp_o = RS_NAK;
                    else
                        rsp_o = RS_GO;
                end
                SG_STATUS: begin
                    if (to_status)
                        rsp_o = status_answer(busy_i, err_i);
                    else
                        rsp_o = RS_STALL;
                end
                default:   rsp_o = RS_STALL;
            endcase
        end

        if (tok_kind_i == TK_SETUP)
            tog_o = 1'b0;
        else if (flip_o || stage_i == SG_STATUS)
            tog_o = 1'b1;
        else
            tog_o = tog_i;
    end

endmodule

// File: rtl/ctl_stage_fsm.sv
module ctl_stage_fsm
    import ctl_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tok_valid_i,
    input  tok_e   tok_kind_i,
    input  rsp_e   rsp_i,
    input  logic   flip_i,
    input  logic   txn_done_i,
    input  logic   setup_in_i,
    input  logic   setup_zero_i,
    input  logic   over_i,
    output stage_e stage_o,
    output logic   stat_in_o,
    output logic   tog_o,
    output logic   load_o,
    output logic   take_o
);

    typedef struct packed {
        stage_e stage;
        logic   stat_in;
        logic   tog;
        tok_e   last;
    } fsm_t;

    fsm_t f_d, f_q;

    logic last_io;
    logic last_status;
    logic tok_io;

    always_comb begin
        f_d         = f_q;
        load_o      = 1'b0;
        take_o      = 1'b0;
        last_io     = (f_q.last == TK_IN) || (f_q.last == TK_OUT);
        last_status = last_io && ((f_q.last == TK_IN) == f_q.stat_in);
        tok_io      = (tok_kind_i == TK_IN) || (tok_kind_i == TK_OUT);

        if (txn_done_i) begin
            if (f_q.last == TK_SETUP) begin
                load_o = 1'b1;
                f_d.tog = 1'b1;
                if (setup_zero_i) begin
                    f_d.stage   = SG_STATUS;
                    f_d.stat_in = 1'b1;
                end else begin
                    f_d.stage   = SG_DATA;
                    f_d.stat_in = ~setup_in_i;
                end
            end else if (f_q.stage == SG_DATA && last_io && !last_status) begin
                take_o  = 1'b1;
                f_d.tog = ~f_q.tog;
                if (over_i)
                    f_d.stage = SG_HALT;
            end else if (f_q.stage == SG_STATUS && last_status) begin
                f_d.stage = SG_IDLE;
                f_d.tog   = 1'b0;
            end
        end else if (tok_valid_i) begin
            f_d.last = tok_kind_i;
            if (tok_io) begin
                if (rsp_i == RS_STALL) begin
                    f_d.stage = SG_HALT;
                end else if (flip_i) begin
                    f_d.stage = SG_STATUS;
                    f_d.tog   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            f_q <= '{stage: SG_IDLE, stat_in: 1'b1, tog: 1'b0, last: TK_RSVD};
        else
            f_q <= f_d;
    end

    assign stage_o   = f_q.stage;
    assign stat_in_o = f_q.stat_in;
    assign tog_o     = f_q.tog;

endmodule

// File: rtl/ctl_xfer_seq.sv
module ctl_xfer_seq
    import ctl_seq_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int LEN_W   = 16,
    localparam int PKT_W  = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             txn_done,
    input  logic [PKT_W-1:0] txn_bytes,
    input  logic             setup_dev2host,
    input  logic [LEN_W-1:0] setup_len,
    input  logic             fn_busy,
    input  logic             fn_error,
    output logic [1:0]       rsp_mode,
    output logic             tog_preset,
    output logic [1:0]       stage
);

    tok_e   kind_w;
    rsp_e   rsp_w;
    stage_e stage_w;
    logic   stat_in_w;
    logic   tog_w;
    logic   flip_w;
    logic   load_w;
    logic   take_w;
    logic   ended_w;
    logic   over_w;
    logic   zero_w;

    assign kind_w = tok_e'(tok_kind);
    assign zero_w = (setup_len == '0);

    ctl_len_meter #(
        .MAX_PKT (MAX_PKT),
        .LEN_W   (LEN_W),
        .PKT_W   (PKT_W)
    ) u_meter (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_w),
        .load_len_i   (setup_len),
        .take_i       (take_w),
        .take_bytes_i (txn_bytes),
        .ended_o      (ended_w),
        .over_o       (over_w)
    );

    ctl_resp_sel u_resp (
        .stage_i    (stage_w),
        .stat_in_i  (stat_in_w),
        .ended_i    (ended_w),
        .tog_i      (tog_w),
        .tok_kind_i (kind_w),
        .busy_i     (fn_busy),
        .err_i      (fn_error),
        .rsp_o      (rsp_w),
        .tog_o      (tog_preset),
        .flip_o     (flip_w)
    );

    ctl_stage_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tok_valid_i  (tok_valid),
        .tok_kind_i   (kind_w),
        .rsp_i        (rsp_w),
        .flip_i       (flip_w),
        .txn_done_i   (txn_done),
        .setup_in_i   (setup_dev2host),
        .setup_zero_i (zero_w),
        .over_i       (over_w),
        .stage_o      (stage_w),
        .stat_in_o    (stat_in_w),
        .tog_o        (tog_w),
        .load_o       (load_w),
        .take_o       (take_w)
    );

    assign rsp_mode = rsp_w;
    assign stage    = stage_w;

endmodule

// File: rtl/ctl_seq_chk.sv
module ctl_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tok_valid,
    input logic [1:0] tok_kind,
    input logic       txn_done,
    input logic       fn_error,
    input logic [1:0] rsp_mode,
    input logic       tog_preset,
    input logic [1:0] stage
);

    logic io_tok;
    assign io_tok = tok_valid && (tok_kind == 2'd1 || tok_kind == 2'd2);

    // R1
    p_setup_go_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == 2'd0) |-> (rsp_mode == 2'd0 && !tog_preset));

    // R9
    p_halt_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_tok && stage == 2'd3) |-> rsp_mode == 2'd2);

    // R9
    p_halt_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 2'd3 && !txn_done) |=> stage == 2'd3);

    // R9
    p_stall_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_tok && rsp_mode == 2'd2 && !txn_done) |=> stage == 2'd3);

    // R6
    p_status_tog_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_tok && stage == 2'd2) |-> tog_preset);

    // R7 and R10
    p_error_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_tok && fn_error) |-> rsp_mode == 2'd2);

    // R11
    p_idle_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (io_tok && stage == 2'd0) |-> rsp_mode == 2'd2);

endmodule

bind ctl_xfer_seq ctl_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tok_valid  (tok_valid),
    .tok_kind   (tok_kind),
    .txn_done   (txn_done),
    .fn_error   (fn_error),
    .rsp_mode   (rsp_mode),
    .tog_preset (tog_preset),
    .stage      (stage)
);

// File: tb/sim_ctl_xfer_seq.sv
module sim_ctl_xfer_seq;

    localparam int CLK_P = 10;
    localparam int MPS   = 64;
    localparam int LW    = 16;
    localparam int PW    = $clog2(MPS + 1);

    localparam logic [1:0] K_SET = 2'd0, K_OUT = 2'd1, K_IN = 2'd2;
    localparam int R_GO = 0, R_NAK = 1, R_STL = 2;
    localparam int S_IDLE = 0, S_DATA = 1, S_STAT = 2, S_HALT = 3;
    localparam int T_ANY = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tok_valid = 1'b0;
    logic [1:0]    tok_kind = 2'd3;
    logic          txn_done = 1'b0;
    logic [PW-1:0] txn_bytes = '0;
    logic          setup_dev2host = 1'b0;
    logic [LW-1:0] setup_len = '0;
    logic          fn_busy = 1'b0;
    logic          fn_error = 1'b0;
    logic [1:0]    rsp_mode;
    logic          tog_preset;
    logic [1:0]    stage;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        int    rsp;
        int    tog;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    ctl_xfer_seq #(.MAX_PKT(MPS), .LEN_W(LW)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .tok_valid      (tok_valid),
        .tok_kind       (tok_kind),
        .txn_done       (txn_done),
        .txn_bytes      (txn_bytes),
        .setup_dev2host (setup_dev2host),
        .setup_len      (setup_len),
        .fn_busy        (fn_busy),
        .fn_error       (fn_error),
        .rsp_mode       (rsp_mode),
        .tog_preset     (tog_preset),
        .stage          (stage)
    );

    // Driver: present one token and queue what should come back
    task automatic tok(input logic [1:0] k, input bit busy, input bit err,
                       input int rsp, input int tog, input string tag);
        exp_t e;
        @(negedge clk);
        tok_valid = 1'b1;
        tok_kind  = k;
        fn_busy   = busy;
        fn_error  = err;
        e.rsp = rsp;
        e.tog = tog;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        tok_valid = 1'b0;
        fn_busy   = 1'b0;
        fn_error  = 1'b0;
    endtask

    task automatic done(input int bytes, input bit d2h, input int len);
        @(negedge clk);
        txn_done       = 1'b1;
        txn_bytes      = PW'(bytes);
        setup_dev2host = d2h;
        setup_len      = LW'(len);
        @(negedge clk);
        txn_done = 1'b0;
    endtask

    task automatic setup(input bit d2h, input int len, input string tag);
        tok(K_SET, 0, 0, R_GO, 0, tag);
        done(0, d2h, len);
    endtask

    task automatic chk_stage(input int exp, input string tag);
        @(negedge clk);
        #(CLK_P/4);
        n_run++;
        if (int'(stage) != exp) begin
            n_fail++;
            $display("FAIL %s: stage actual %0d expected %0d", tag, stage, exp);
        end
    endtask

    // Monitor: compare each presented token's answer with the queue
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (tok_valid) begin
                exp_t e;
                n_run++;
                if (sb.size() == 0) begin
                    n_fail++;
                    $display("FAIL monitor: unexpected token actual %0d expected none", rsp_mode);
                end else begin
                    e = sb.pop_front();
                    if (int'(rsp_mode) != e.rsp ||
                        (e.tog != T_ANY && int'(tog_preset) != e.tog)) begin
                        n_fail++;
                        $display("FAIL %s: rsp/tog actual %0d/%0d expected %0d/%0d",
                                 e.tag, rsp_mode, tog_preset, e.rsp, e.tog);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_stage(S_IDLE, "R11 reset");

        // Idle token, then sticky halt
        tok(K_IN, 0, 0, R_STL, 0, "R11 idle IN");
        chk_stage(S_HALT, "R9 halt entry");
        tok(K_OUT, 0, 0, R_STL, T_ANY, "R9 sticky OUT");

        // Control read, len 100, from halt
        setup(1, 100, "R1 setup in halt");
        chk_stage(S_DATA, "R2 read data stage");
        tok(K_IN, 0, 0, R_GO, 1, "R3 first data");
        done(64, 0, 0);
        tok(K_IN, 0, 0, R_GO, 0, "R3 toggled");
        done(36, 0, 0);
        tok(K_OUT, 0, 0, R_GO, 1, "R6 status start");
        chk_stage(S_STAT, "R6 status stage");
        done(5, 0, 0);
        chk_stage(S_IDLE, "R7 status any length");

        // Control write with busy phases
        setup(0, 10, "R1 setup idle");
        tok(K_OUT, 1, 0, R_NAK, 1, "R10 busy data");
        chk_stage(S_DATA, "R10 nak keeps stage");
        tok(K_OUT, 0, 0, R_GO, 1, "R3 nak keeps toggle");
        done(10, 0, 0);
        tok(K_IN, 1, 0, R_NAK, 1, "R7 busy status");
        chk_stage(S_STAT, "R6 write status stage");
        tok(K_IN, 0, 0, R_GO, 1, "R7 status complete");
        done(0, 0, 0);
        chk_stage(S_IDLE, "R7 write done");

        // No data stage
        setup(1, 0, "R1 setup nodata");
        chk_stage(S_STAT, "R2 zero length");
        tok(K_OUT, 0, 0, R_STL, 1, "R8 wrong status dir");
        chk_stage(S_HALT, "R9 halt from status");
        tok(K_IN, 0, 0, R_STL, T_ANY, "R9 sticky IN");
        setup(0, 0, "R1 setup clears");
        tok(K_IN, 0, 0, R_GO, 1, "R2 status is IN");
        done(0, 0, 0);
        chk_stage(S_IDLE, "R2 nodata done");

        // Over-request
        setup(1, 64, "R1 setup 64");
        tok(K_IN, 0, 0, R_GO, 1, "R3 single");
        done(64, 0, 0);
        tok(K_IN, 0, 0, R_STL, 0, "R4 exhausted");
        chk_stage(S_HALT, "R9 over-request halt");
        tok(K_OUT, 0, 0, R_STL, T_ANY, "R9 no status stage");

        // Zero-length end of data stage
        setup(1, 255, "R1 setup 255");
        tok(K_IN, 0, 0, R_GO, 1, "R3 zlp seq a");
        done(64, 0, 0);
        tok(K_IN, 0, 0, R_GO, 0, "R3 zlp seq b");
        done(64, 0, 0);
        tok(K_IN, 0, 0, R_GO, 1, "R3 zlp seq c");
        done(0, 0, 0);
        tok(K_IN, 0, 0, R_STL, 0, "R4 after zlp");

        // Short packet end
        setup(1, 200, "R1 setup 200");
        tok(K_IN, 0, 0, R_GO, 1, "R3 short seq");
        done(10, 0, 0);
        tok(K_IN, 0, 0, R_STL, 0, "R4 after short");

        // Receipt of too much data
        setup(0, 20, "R1 setup 20");
        tok(K_OUT, 0, 0, R_GO, 1, "R3 over seq");
        done(30, 0, 0);
        chk_stage(S_HALT, "R5 overrun halt");
        tok(K_IN, 0, 0, R_STL, T_ANY, "R9 after overrun");

        // Lost ACK on last IN
        setup(1, 64, "R1 setup lost ack");
        tok(K_IN, 0, 0, R_GO, 1, "R3 unacked IN");
        tok(K_OUT, 0, 0, R_GO, 1, "R6 lost ack status");
        chk_stage(S_STAT, "R6 lost ack stage");
        done(0, 0, 0);
        chk_stage(S_IDLE, "R7 lost ack done");

        // Function errors
        setup(0, 40, "R1 setup err");
        tok(K_OUT, 0, 1, R_STL, 1, "R10 data error");
        chk_stage(S_HALT, "R10 error halt");
        setup(0, 4, "R1 setup err2");
        tok(K_OUT, 0, 0, R_GO, 1, "R3 err2 data");
        done(4, 0, 0);
        tok(K_IN, 0, 1, R_STL, 1, "R7 status error");
        chk_stage(S_HALT, "R9 status error halt");

        @(negedge clk);
        n_run++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: pending actual %0d expected 0", sb.size());
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule